// File: doc/BRIEF.md
# Coalescing Store Buffer with Byte-Granular Load Forwarding

This block sits between a core's load/store pipeline and a memory port, and handles ordinary cacheable-style memory traffic only. Stores come in on a valid/ready stream. Each store carries an address and a byte-enable mask over one 8-byte lane, so a byte, halfword, word or doubleword is simply a different mask. Buffered stores are kept in a small set of entries. Each entry holds a doubleword-aligned tag, 64 data bits, 8 byte-valid bits and an age rank. A new store to the same doubleword as an entry that has not yet been offered to memory is folded into that entry byte by byte. Entries are written back to memory one at a time, oldest first, over a valid/ready write port, and an entry is freed when the write is accepted.

Loads also come in on a valid/ready stream with an address and byte mask. Each requested byte is taken from the youngest buffered store that covers it. When every requested byte is covered, the result is returned without touching memory. Otherwise the block issues one doubleword read on a valid/ready read port, waits for the read data, and fills the uncovered bytes from it. Back-pressure rules are as follows. `st_ready` is low while a load is outstanding, and also when no free or mergeable entry exists. `ld_ready` is low while a store is being offered or while a load is outstanding. Both `wr_valid` and `ld_rsp_valid` hold their payload steady until accepted. `rd_rsp_valid` has no back-pressure.

Top module: `stbuf_fwd`

## Requirements
- R1: After reset, `wr_valid`, `rd_valid` and `ld_rsp_valid` are 0, `st_ready` is 1, and `ld_ready` is 1 while `st_valid` is 0.
- R2: A written-back entry shows its doubleword-aligned address (low 3 bits zero) on `wr_addr`, exactly the union of accepted store masks on `wr_be` (bit n is byte n of the lane, never all zero), and those bytes on `wr_data` lanes [8n+7:8n]. After draining, memory holds the program-order result of all stores.
- R3: A store whose doubleword matches an entry not yet offered to memory updates only its enabled bytes in that entry, and later bytes replace earlier ones. That doubleword then produces a single write carrying the merged mask and data.
- R4: A store to the doubleword of an entry already offered on the write port does not alter the offered transaction. It occupies a new entry and is written after it.
- R5: Entries are written back oldest first, where both allocation and a merge make an entry the youngest.
- R6: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr`, `wr_be` and `wr_data` hold. An entry is freed on the accepting edge, and the port goes idle once the buffer is empty.
- R7: When every entry is in use and the store matches no mergeable entry, `st_ready` is 0 and no store is taken until a write completes. A store that can merge is still accepted at once.
- R8: A load whose requested bytes are all covered by buffered stores returns `ld_rsp_valid` in the cycle after acceptance, without a memory read.
- R9: A load with an uncovered requested byte issues one read on `rd_addr` for its aligned doubleword. Covered bytes come from the buffer, uncovered requested bytes come from `rd_rsp_data`, and unrequested bytes are zero.
- R10: Every returned byte equals the value written by the youngest store to that byte in program order, even when several entries hold the same byte.
- R11: `ld_ready` is 0 while `st_valid` is 1, and `st_ready` is 0 from load acceptance until the response is taken.
- R12: While `ld_rsp_valid` is 1 and `ld_rsp_ready` is 0, the response holds with stable `ld_rsp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle when valid |
| st_addr | input | ADDR_W | Store byte address (low 3 bits ignored) |
| st_be | input | 8 | Store byte mask within the doubleword |
| st_data | input | 64 | Store data, lane-positioned |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load accepted this cycle when valid |
| ld_addr | input | ADDR_W | Load byte address (low 3 bits ignored) |
| ld_be | input | 8 | Load byte mask |
| ld_rsp_valid | output | 1 | Load result available |
| ld_rsp_ready | input | 1 | Load result taken |
| ld_rsp_data | output | 64 | Load result, unrequested bytes zero |
| wr_valid | output | 1 | Write-back request |
| wr_ready | input | 1 | Write-back accepted by memory |
| wr_addr | output | ADDR_W | Aligned write address |
| wr_be | output | 8 | Write byte mask |
| wr_data | output | 64 | Write data |
| rd_valid | output | 1 | Memory read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Aligned read address |
| rd_rsp_valid | input | 1 | Read data returning |
| rd_rsp_data | input | 64 | Read data |

## Verification
A fully forwarded load answers on the edge after its accepting edge. A load that needs memory raises `rd_valid` one edge after acceptance, and answers one edge after `rd_rsp_valid`. With the bench's one-cycle memory, that is three edges in total. The bench counts falling edges from the accepting edge, so it checks both the data and the latency it expects. A store accepted at one edge appears on the write port two edges later, because allocation and selection each take one register. The bench therefore samples the write port at the second falling edge, and it logs each accepted write to compare the drain order and the merged masks afterwards.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int SBF_ADDR_W = 32;
  localparam int SBF_ENTRIES = 4;
  localparam int SBF_LANES = 8;

  typedef enum logic [1:0] {
    LD_IDLE   = 2'd0,
    LD_RDREQ  = 2'd1,
    LD_RDWAIT = 2'd2,
    LD_RESP   = 2'd3
  } ld_state_e;
endpackage

// File: rtl/sbf_oldest.sv
module sbf_oldest #(
  parameter int NUM_ENT = 4,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0]            cand,
  input  logic [NUM_ENT-1:0][IDX_W-1:0] age,
  output logic                          any,
  output logic [IDX_W-1:0]              idx
);
  logic [IDX_W-1:0] best;

  // Largest age rank among candidates is the oldest entry.
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (cand[i] && (!any || age[i] > best)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = age[i];
      end
    end
  end
endmodule

// File: rtl/sbf_fwd.sv
module sbf_fwd #(
  parameter int NUM_ENT = 4,
  parameter int LANES = 8,
  localparam int IDX_W = $clog2(NUM_ENT),
  localparam int DATA_W = LANES * 8
) (
  input  logic [NUM_ENT-1:0]             match,
  input  logic [NUM_ENT-1:0][LANES-1:0]  ent_be,
  input  logic [NUM_ENT-1:0][DATA_W-1:0] ent_data,
  input  logic [NUM_ENT-1:0][IDX_W-1:0]  ent_age,
  output logic [LANES-1:0]               hit,
  output logic [DATA_W-1:0]              data
);
  // One youngest-writer search per byte lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic             found;
    logic [IDX_W-1:0] best;
    logic [7:0]       val;
    always_comb begin
      found = 1'b0;
      best  = '0;
      val   = '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        if (match[i] && ent_be[i][g] && (!found || ent_age[i] < best)) begin
          found = 1'b1;
          best  = ent_age[i];
          val   = ent_data[i][8*g +: 8];
        end
      end
    end
    assign hit[g]          = found;
    assign data[8*g +: 8]  = val;
  end
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd
  import sbf_pkg::*;
#(
  parameter int ADDR_W = SBF_ADDR_W,
  parameter int NUM_ENT = SBF_ENTRIES,
  parameter int LANES = SBF_LANES,
  localparam int DATA_W = LANES * 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [LANES-1:0]  st_be,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LANES-1:0]  ld_be,
  output logic              ld_rsp_valid,
  input  logic              ld_rsp_ready,
  output logic [DATA_W-1:0] ld_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_be,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data
);
  // Entry storage
  logic [NUM_ENT-1:0]             e_vld, e_sent;
  logic [NUM_ENT-1:0][TAG_W-1:0]  e_tag;
  logic [NUM_ENT-1:0][LANES-1:0]  e_be;
  logic [NUM_ENT-1:0][DATA_W-1:0] e_data;
  logic [NUM_ENT-1:0][IDX_W-1:0]  e_age;

  logic             drain_busy;
  logic [IDX_W-1:0] drain_idx;

  ld_state_e         lst;
  logic [TAG_W-1:0]  l_tag;
  logic [LANES-1:0]  l_be, l_hit;
  logic [DATA_W-1:0] l_data;

  wire [TAG_W-1:0] st_tag = st_addr[ADDR_W-1:OFF_W];
  wire [TAG_W-1:0] ld_tag = ld_addr[ADDR_W-1:OFF_W];
  logic unused_low;
  assign unused_low = ^{st_addr[OFF_W-1:0], ld_addr[OFF_W-1:0]};

  // Merge target and free slot search
  logic             merge_any, free_any;
  logic [IDX_W-1:0] merge_idx, free_idx;
  always_comb begin
    merge_any = 1'b0; merge_idx = '0;
    free_any  = 1'b0; free_idx  = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (e_vld[i] && !e_sent[i] && e_tag[i] == st_tag) begin
        merge_any = 1'b1;
        merge_idx = IDX_W'(i);
      end
      if (!e_vld[i] && !free_any) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign st_ready = (lst == LD_IDLE) && (merge_any || free_any);
  wire st_fire = st_valid && st_ready;
  wire do_alloc = st_fire && !merge_any;
  wire do_merge = st_fire && merge_any;

  // Drain selection
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  sbf_oldest #(.NUM_ENT(NUM_ENT)) u_oldest (
    .cand (e_vld & ~e_sent),
    .age  (e_age),
    .any  (pick_any),
    .idx  (pick_idx)
  );
  wire pick_go = !drain_busy && pick_any;
  wire wr_fire = wr_valid && wr_ready;
  // A merge into the entry picked this cycle keeps it oldest.
  wire refresh = do_merge && !(pick_go && pick_idx == merge_idx);

  assign wr_valid = drain_busy;
  assign wr_addr  = {e_tag[drain_idx], {OFF_W{1'b0}}};
  assign wr_be    = e_be[drain_idx];
  assign wr_data  = e_data[drain_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld      <= '0;
      e_sent     <= '0;
      e_age      <= '0;
      drain_busy <= 1'b0;
      drain_idx  <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (wr_fire && drain_idx == IDX_W'(i)) begin
          e_vld[i]  <= 1'b0;
          e_sent[i] <= 1'b0;
        end
        if (do_alloc && free_idx == IDX_W'(i)) begin
          e_vld[i]  <= 1'b1;
          e_sent[i] <= 1'b0;
          e_tag[i]  <= st_tag;
          e_be[i]   <= st_be;
          e_data[i] <= st_data;
          e_age[i]  <= '0;
        end else if (do_merge && merge_idx == IDX_W'(i)) begin
          e_be[i] <= e_be[i] | st_be;
          for (int b = 0; b < LANES; b++)
            if (st_be[b]) e_data[i][8*b +: 8] <= st_data[8*b +: 8];
          if (refresh) e_age[i] <= '0;
        end else if (e_vld[i] && do_alloc) begin
          e_age[i] <= IDX_W'(e_age[i] + 1'b1);
        end else if (e_vld[i] && refresh && e_age[i] < e_age[merge_idx]) begin
          e_age[i] <= IDX_W'(e_age[i] + 1'b1);
        end
        if (pick_go && pick_idx == IDX_W'(i)) e_sent[i] <= 1'b1;
      end
      if (wr_fire) begin
        drain_busy <= 1'b0;
      end else if (pick_go) begin
        drain_busy <= 1'b1;
        drain_idx  <= pick_idx;
      end
    end
  end

  // Load forwarding
  logic [NUM_ENT-1:0] ld_match;
  always_comb
    for (int i = 0; i < NUM_ENT; i++) ld_match[i] = e_vld[i] && e_tag[i] == ld_tag;

  logic [LANES-1:0]  fwd_hit;
  logic [DATA_W-1:0] fwd_data, fwd_masked;
  sbf_fwd #(.NUM_ENT(NUM_ENT), .LANES(LANES)) u_fwd (
    .match    (ld_match),
    .ent_be   (e_be),
    .ent_data (e_data),
    .ent_age  (e_age),
    .hit      (fwd_hit),
    .data     (fwd_data)
  );
  always_comb
    for (int b = 0; b < LANES; b++)
      fwd_masked[8*b +: 8] = (ld_be[b] && fwd_hit[b]) ? fwd_data[8*b +: 8] : 8'h00;

  assign ld_ready     = (lst == LD_IDLE) && !st_valid;
  assign rd_valid     = (lst == LD_RDREQ);
  assign rd_addr      = {l_tag, {OFF_W{1'b0}}};
  assign ld_rsp_valid = (lst == LD_RESP);
  assign ld_rsp_data  = l_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lst <= LD_IDLE;
    end else begin
      unique case (lst)
        LD_IDLE:
          if (ld_valid && ld_ready) begin
            l_tag  <= ld_tag;
            l_be   <= ld_be;
            l_hit  <= fwd_hit & ld_be;
            l_data <= fwd_masked;
            lst    <= ((ld_be & ~fwd_hit) == '0) ? LD_RESP : LD_RDREQ;
          end
        LD_RDREQ:
          if (rd_ready) lst <= LD_RDWAIT;
        LD_RDWAIT:
          if (rd_rsp_valid) begin
            for (int b = 0; b < LANES; b++)
              if (!l_hit[b])
                l_data[8*b +: 8] <= l_be[b] ? rd_rsp_data[8*b +: 8] : 8'h00;
            lst <= LD_RESP;
          end
        LD_RESP:
          if (ld_rsp_ready) lst <= LD_IDLE;
        default: lst <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbf_chk.sv
module sbf_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES = 8,
  localparam int DATA_W = LANES * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_ready,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic              ld_rsp_valid,
  input logic              ld_rsp_ready,
  input logic [DATA_W-1:0] ld_rsp_data,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [LANES-1:0]  wr_be,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr
);
  logic ld_pend;
  always_ff @(posedge clk) begin
    if (!rst_n) ld_pend <= 1'b0;
    else if (ld_valid && ld_ready) ld_pend <= 1'b1;
    else if (ld_rsp_valid && ld_rsp_ready) ld_pend <= 1'b0;
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_be) && $stable(wr_data)); // R6
  AST_WR_BE_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_be != '0); // R2
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rsp_valid && !ld_rsp_ready |=> ld_rsp_valid && $stable(ld_rsp_data)); // R12
  AST_NO_STORE_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pend |-> !st_ready); // R11
  AST_RD_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ld_pend); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R9
  AST_RSP_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rsp_valid |-> ld_pend); // R8
endmodule

bind stbuf_fwd sbf_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_ready     (st_ready),
  .ld_valid     (ld_valid),
  .ld_ready     (ld_ready),
  .ld_rsp_valid (ld_rsp_valid),
  .ld_rsp_ready (ld_rsp_ready),
  .ld_rsp_data  (ld_rsp_data),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_be        (wr_be),
  .wr_data      (wr_data),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_addr      (rd_addr)
);

// File: tb/stbuf_fwd_bench.sv
`timescale 1ns/100ps
module stbuf_fwd_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, st_ready;
  logic [31:0] st_addr;
  logic [7:0]  st_be;
  logic [63:0] st_data;
  logic        ld_valid, ld_ready;
  logic [31:0] ld_addr;
  logic [7:0]  ld_be;
  logic        ld_rsp_valid, ld_rsp_ready;
  logic [63:0] ld_rsp_data;
  logic        wr_valid, wr_ready;
  logic [31:0] wr_addr;
  logic [7:0]  wr_be;
  logic [63:0] wr_data;
  logic        rd_valid, rd_ready;
  logic [31:0] rd_addr;
  logic        rd_rsp_valid;
  logic [63:0] rd_rsp_data;

  always #2.5 clk = ~clk;

  stbuf_fwd u_stbuf_fwd (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_be(st_be), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_ready(ld_rsp_ready), .ld_rsp_data(ld_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data)
  );

  // Memory model: 128 bytes, one-cycle read latency, write log.
  logic [7:0]  mem [0:127];
  logic [7:0]  sh  [0:127];
  logic [31:0] wl_addr [0:63];
  logic [7:0]  wl_be   [0:63];
  logic [63:0] wl_data [0:63];
  int wl_n, rd_n;
  assign rd_ready = 1'b1;

  function automatic logic [7:0] init_byte(int i);
    return 8'(i * 7 + 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_byte(i);
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
      wl_n <= 0;
      rd_n <= 0;
    end else begin
      rd_rsp_valid <= rd_valid && rd_ready;
      if (rd_valid && rd_ready) begin
        for (int b = 0; b < 8; b++) rd_rsp_data[8*b +: 8] <= mem[{rd_addr[6:3], 3'(b)}];
        rd_n <= rd_n + 1;
      end
      if (wr_valid && wr_ready) begin
        for (int b = 0; b < 8; b++)
          if (wr_be[b]) mem[{wr_addr[6:3], 3'(b)}] <= wr_data[8*b +: 8];
        wl_addr[wl_n[5:0]] <= wr_addr;
        wl_be[wl_n[5:0]]   <= wr_be;
        wl_data[wl_n[5:0]] <= wr_data;
        wl_n <= wl_n + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  task automatic do_store(input logic [31:0] a, input logic [7:0] be,
                          input logic [63:0] d, output int waits);
    waits = 0;
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_be = be; st_data = d;
    #1;
    while (!st_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    st_valid = 1'b0;
    for (int b = 0; b < 8; b++)
      if (be[b]) sh[{a[6:3], 3'(b)}] = d[8*b +: 8];
  endtask

  function automatic logic [63:0] expect_load(logic [31:0] a, logic [7:0] be);
    logic [63:0] r;
    r = '0;
    for (int b = 0; b < 8; b++)
      if (be[b]) r[8*b +: 8] = sh[{a[6:3], 3'(b)}];
    return r;
  endfunction

  task automatic do_load(input logic [31:0] a, input logic [7:0] be, input bit hold,
                         output logic [63:0] d, output int lat, output logic st_rdy_seen);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_be = be;
    ld_rsp_ready = !hold;
    #1;
    while (!ld_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    ld_valid = 1'b0;
    lat = 0;
    @(negedge clk);
    lat++;
    st_rdy_seen = st_ready;
    while (!ld_rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    d = ld_rsp_data;
    if (hold) begin
      repeat (2) begin
        @(negedge clk);
        chk("R12 response held", {63'd0, ld_rsp_valid}, 64'd1);
        chk("R12 response data stable", ld_rsp_data, d);
      end
      ld_rsp_ready = 1'b1;
    end
    @(posedge clk);
    #1;
  endtask

  // Vectors: [88] 1=store 0=load, [87:72] address, [71:64] byte mask, [63:0] store data.
  localparam int NV = 16;
  localparam logic [88:0] VEC [NV] = '{
    {1'b1, 16'h0040, 8'hFF, 64'h1122334455667788},
    {1'b1, 16'h0042, 8'h0C, 64'h00000000BEEF0000},
    {1'b0, 16'h0040, 8'h0F, 64'h0},
    {1'b1, 16'h0044, 8'hF0, 64'hCAFEF00D00000000},
    {1'b1, 16'h0045, 8'h20, 64'h00005A0000000000},
    {1'b0, 16'h0040, 8'hFF, 64'h0},
    {1'b1, 16'h0048, 8'h01, 64'h00000000000000AB},
    {1'b0, 16'h0048, 8'h03, 64'h0},
    {1'b0, 16'h004E, 8'hC0, 64'h0},
    {1'b1, 16'h0050, 8'h3C, 64'h0000123456780000},
    {1'b1, 16'h0050, 8'h18, 64'h0000007766000000},
    {1'b0, 16'h0050, 8'hFF, 64'h0},
    {1'b0, 16'h0052, 8'h0C, 64'h0},
    {1'b1, 16'h0058, 8'hFF, 64'h0123456789ABCDEF},
    {1'b0, 16'h005C, 8'hF0, 64'h0},
    {1'b0, 16'h0058, 8'h01, 64'h0}
  };

  initial begin
    logic [63:0] d;
    int lat, waits, r0, w0;
    logic srdy;
    for (int i = 0; i < 128; i++) sh[i] = init_byte(i);
    rst_n = 1'b0;
    st_valid = 0; st_addr = '0; st_be = '0; st_data = '0;
    ld_valid = 0; ld_addr = '0; ld_be = '0; ld_rsp_ready = 1'b1;
    wr_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr_valid idle", {63'd0, wr_valid}, 64'd0);
    chk("R1 rd_valid idle", {63'd0, rd_valid}, 64'd0);
    chk("R1 ld_rsp_valid idle", {63'd0, ld_rsp_valid}, 64'd0);
    chk("R1 st_ready", {63'd0, st_ready}, 64'd1);
    chk("R1 ld_ready", {63'd0, ld_ready}, 64'd1);

    // Vector walk with memory always ready.
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][88]) begin
        do_store({16'h0, VEC[k][87:72]}, VEC[k][71:64], VEC[k][63:0], waits);
      end else begin
        do_load({16'h0, VEC[k][87:72]}, VEC[k][71:64], 1'b0, d, lat, srdy);
        chk("R10 load sees youngest bytes", d, expect_load({16'h0, VEC[k][87:72]}, VEC[k][71:64]));
      end
    end
    repeat (10) @(negedge clk);
    chk("R6 port idle after drain", {63'd0, wr_valid}, 64'd0);

    // Directed: stalled memory, merging, ordering.
    wr_ready = 1'b0;
    w0 = wl_n;
    do_store(32'h20, 8'h0F, 64'h00000000A1A2A3A4, waits);
    repeat (2) @(negedge clk);
    chk("R2 wr_valid after two edges", {63'd0, wr_valid}, 64'd1);
    chk("R2 wr_addr aligned", {32'd0, wr_addr}, 64'h20);
    chk("R2 wr_be", {56'd0, wr_be}, 64'h0F);
    repeat (3) @(negedge clk);
    chk("R6 wr held while stalled", {32'd0, wr_addr, 24'd0, wr_be}, {32'h20, 24'd0, 8'h0F});

    do_store(32'h28, 8'h01, 64'h11, waits);
    do_store(32'h2A, 8'h0C, 64'h0000000022330000, waits);
    do_store(32'h28, 8'h01, 64'h44, waits);
    r0 = rd_n;
    do_load(32'h28, 8'h03, 1'b0, d, lat, srdy);
    chk("R9 partial load data", d, expect_load(32'h28, 8'h03));
    chk("R9 partial load latency", 64'(lat), 64'd3);
    chk("R9 one memory read", 64'(rd_n - r0), 64'd1);
    chk("R11 st_ready low while load pending", {63'd0, srdy}, 64'd0);
    r0 = rd_n;
    do_load(32'h28, 8'h0D, 1'b0, d, lat, srdy);
    chk("R8 covered load data", d, expect_load(32'h28, 8'h0D));
    chk("R8 covered load latency", 64'(lat), 64'd1);
    chk("R8 no memory read", 64'(rd_n - r0), 64'd0);

    do_store(32'h20, 8'h3C, 64'h0000E5E4E3E20000, waits);
    chk("R4 offered write untouched", {32'd0, wr_addr, wr_data[31:0]}, {32'h20, 32'hA1A2A3A4});
    chk("R4 offered mask untouched", {56'd0, wr_be}, 64'h0F);
    do_load(32'h20, 8'h0F, 1'b1, d, lat, srdy);
    chk("R10 two entries same byte", d, expect_load(32'h20, 8'h0F));
    do_store(32'h30, 8'hFF, 64'hF7F6F5F4F3F2F1F0, waits);
    do_store(32'h28, 8'h80, 64'h9900000000000000, waits);
    chk("R7 merge accepted while full", 64'(waits), 64'd0);

    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h38; st_be = 8'hFF; st_data = 64'h5555AAAA5555AAAA;
    ld_valid = 1'b1; ld_addr = 32'h30; ld_be = 8'hFF;
    #1;
    chk("R11 ld_ready low during store", {63'd0, ld_ready}, 64'd0);
    chk("R7 st_ready low when full", {63'd0, st_ready}, 64'd0);
    ld_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 still stalled", {63'd0, st_ready}, 64'd0);
    chk("R7 no write completed", 64'(wl_n - w0), 64'd0);
    wr_ready = 1'b1;
    #1;
    while (!st_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    st_valid = 1'b0;
    for (int b = 0; b < 8; b++) sh[32'h38 + b] = st_data[8*b +: 8];

    repeat (15) @(negedge clk);
    chk("R5 write count", 64'(wl_n - w0), 64'd5);
    chk("R5 order 1", {32'd0, wl_addr[w0]},     64'h20);
    chk("R4 order 2 second X entry", {32'd0, wl_addr[w0 + 1]}, 64'h20);
    chk("R5 order 3", {32'd0, wl_addr[w0 + 2]}, 64'h30);
    chk("R5 order 4 refreshed entry", {32'd0, wl_addr[w0 + 3]}, 64'h28);
    chk("R5 order 5", {32'd0, wl_addr[w0 + 4]}, 64'h38);
    chk("R4 second X mask", {56'd0, wl_be[w0 + 1]}, 64'h3C);
    chk("R3 merged mask", {56'd0, wl_be[w0 + 3]}, 64'h8D);
    chk("R3 merged data", wl_data[w0 + 3] & 64'hFF000000FFFF00FF, 64'h9900000022330044);
    chk("R6 idle after drain", {63'd0, wr_valid}, 64'd0);
    for (int a = 32; a < 64; a += 8) begin
      do_load(32'(a), 8'hFF, 1'b0, d, lat, srdy);
      chk("R2 memory in program order", d, expect_load(32'(a), 8'hFF));
    end
    finish_run();
  end
endmodule